// File: doc/BRIEF.md
# Colour Lookup Table Register Interface

This block holds the colour lookup table of a display controller. There are 256 pixel entries and 4 overlay entries, and each entry stores 8-bit red, green and blue values. A host reaches the table through single-cycle 32-bit register accesses at four byte offsets. Only byte lane 31:24 carries a colour or index value.

To load the table, the host first writes an index. It then streams channel bytes through a data register. A two-bit phase counter chooses red, then green, then blue. After each blue byte the index moves on to the next entry. Reads follow the same phase sequence through the indexed pixel entry and use the same counter, so a read continues wherever the last access stopped.

A pixel pipeline looks up colours through a separate combinational port. Overlay entries 2 and 3 drive their own two output ports, for use by a cursor.

Top module: `clut_regs`

## Requirements
- R1: After reset, every entry is black (0x000000) except pixel entry 255 and overlay entries 0 and 2, which are white (0xFFFFFF). The index and the phase are both 0.
- R2: A write to offset 0x0 loads the index from wdata[31:24] and sets the phase to 0 (red).
- R3: A write to offset 0x4 stores wdata[31:24] into one channel of the pixel entry at the index. Phase 0 selects red, phase 1 green and phase 2 blue. After a red or green write the phase advances by one and the index does not change.
- R4: After a data write in phase 2 (blue), the index increments modulo 256 and the phase returns to 0.
- R5: A write to offset 0xC stores into overlay entry index[1:0] instead of a pixel entry. It uses the same phase order and the same increment after blue, and it leaves the pixel entries unchanged.
- R6: While rd_en is high, rdata is {channel byte, 24'h0} in the same cycle. The channel byte is the one the phase selects from the pixel entry at the index. Each read advances the phase and the index in the same way as a data write, through the same shared counter.
- R7: A write to offset 0x8, or to any other offset outside 0x0, 0x4 and 0xC, changes no entry, no index and no phase.
- R8: pix_rgb equals {R,G,B} of the pixel entry selected by pix_idx, combinationally.
- R9: ovl2_rgb and ovl3_rgb equal {R,G,B} of overlay entries 2 and 3. They change only after a write to offset 0xC.
- R10: When wr_en and rd_en are high in the same cycle, the write takes effect and the read does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one access per cycle |
| rd_en | input | 1 | Register read strobe, one access per cycle |
| addr | input | 4 | Byte offset of the register access |
| wdata | input | 32 | Write data; bits 31:24 are used |
| rdata | output | 32 | Read data; channel byte in bits 31:24 |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Looked-up colour {R,G,B} |
| ovl2_rgb | output | 24 | Overlay entry 2 {R,G,B} |
| ovl3_rgb | output | 24 | Overlay entry 3 {R,G,B} |

## Verification
Table writes, index loads and counter steps are registered. Their effect is visible one clock edge after the strobe, so the bench drives each access on a falling edge and observes its effect on the next falling edge. rdata and pix_rgb are combinational. The bench therefore samples them 1 ns after it applies rd_en or pix_idx, within the same cycle and before the edge that advances the counter. The overlay outputs are checked after the write edge.

// File: rtl/clut_regs.sv
module clut_regs #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  parameter int OVL_W = 2,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [3*CH_W-1:0] pix_rgb,
  output logic [3*CH_W-1:0] ovl2_rgb,
  output logic [3*CH_W-1:0] ovl3_rgb
);
  localparam int NPIX  = 1 << IDX_W;
  localparam int NOVL  = 1 << OVL_W;
  localparam int RGB_W = 3 * CH_W;
  localparam logic [RGB_W-1:0] WHITE = '1;

  logic [RGB_W-1:0] pix_q [NPIX];
  logic [RGB_W-1:0] ovl_q [NOVL];
  logic [IDX_W-1:0] idx_q;
  logic [1:0]       phase_q;

  wire sel_idx = addr == AW'(0);
  wire sel_pix = addr == AW'(4);
  wire sel_ovl = addr == AW'(12);
  wire [CH_W-1:0] wbyte = wdata[DW-1 -: CH_W];
  wire data_wr = wr_en && (sel_pix || sel_ovl);
  wire step    = data_wr || (rd_en && !wr_en);
  wire unused_wbits = ^wdata[DW-CH_W-1:0];

  function automatic logic [RGB_W-1:0] put_ch(logic [RGB_W-1:0] old, logic [1:0] ph,
                                               logic [CH_W-1:0] b);
    logic [RGB_W-1:0] v;
    v = old;
    case (ph)
      2'd0:    v[3*CH_W-1 -: CH_W] = b;
      2'd1:    v[2*CH_W-1 -: CH_W] = b;
      default: v[CH_W-1   -: CH_W] = b;
    endcase
    return v;
  endfunction

  function automatic logic [CH_W-1:0] get_ch(logic [RGB_W-1:0] v, logic [1:0] ph);
    case (ph)
      2'd0:    return v[3*CH_W-1 -: CH_W];
      2'd1:    return v[2*CH_W-1 -: CH_W];
      default: return v[CH_W-1   -: CH_W];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      phase_q <= '0;
    end else if (wr_en && sel_idx) begin
      idx_q   <= wdata[DW-1 -: IDX_W];
      phase_q <= '0;
    end else if (step) begin
      if (phase_q >= 2'd2) begin
        idx_q   <= idx_q + 1'b1;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  for (genvar e = 0; e < NPIX; e++) begin : g_pix
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pix_q[e] <= (e == NPIX - 1) ? WHITE : '0;
      else if (wr_en && sel_pix && idx_q == IDX_W'(e))
        pix_q[e] <= put_ch(pix_q[e], phase_q, wbyte);
    end
  end

  for (genvar o = 0; o < NOVL; o++) begin : g_ovl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ovl_q[o] <= (o == 0 || o == 2) ? WHITE : '0;
      else if (wr_en && sel_ovl && idx_q[OVL_W-1:0] == OVL_W'(o))
        ovl_q[o] <= put_ch(ovl_q[o], phase_q, wbyte);
    end
  end

  assign rdata    = {get_ch(pix_q[idx_q], phase_q), {(DW-CH_W){1'b0}}};
  assign pix_rgb  = pix_q[pix_idx];
  assign ovl2_rgb = ovl_q[2];
  assign ovl3_rgb = ovl_q[3];
endmodule

module clut_regs_chk #(
  parameter int IDX_W = 8,
  parameter int CH_W  = 8,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [DW-1:0]     wdata,
  input logic [IDX_W-1:0]  idx_q,
  input logic [1:0]        phase_q,
  input logic [3*CH_W-1:0] ovl2_rgb,
  input logic [3*CH_W-1:0] ovl3_rgb
);
  wire is_data  = addr == AW'(4) || addr == AW'(12);
  wire is_other = !(is_data || addr == AW'(0));

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == AW'(0) |=> idx_q == $past(wdata[DW-1 -: IDX_W]) && phase_q == 2'd0);
  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && is_data && phase_q < 2'd2 |=> phase_q == $past(phase_q) + 2'd1 && $stable(idx_q));
  // R4
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && is_data && phase_q == 2'd2 |=> phase_q == 2'd0 && idx_q == IDX_W'($past(idx_q) + 1'b1));
  // R7
  ctrl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && is_other |=> $stable(idx_q) && $stable(phase_q));
  // R10
  rd_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && rd_en && is_other |=> $stable(phase_q));
  // R9
  ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(12)) |=> $stable(ovl2_rgb) && $stable(ovl3_rgb));
  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n) phase_q != 2'd3);
endmodule

bind clut_regs clut_regs_chk #(.IDX_W(IDX_W), .CH_W(CH_W), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_clut_regs.sv
module test_clut_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [7:0] pix_idx = 0;
  logic [23:0] pix_rgb, ovl2_rgb, ovl3_rgb;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [23:0] m_pix [256];
  logic [23:0] m_ovl [4];
  int midx = 0, mph = 0;

  always #4 clk = ~clk;

  clut_regs i_clut_regs (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] setch(logic [23:0] v, int ph, logic [7:0] b);
    if (ph == 0) v[23:16] = b; else if (ph == 1) v[15:8] = b; else v[7:0] = b;
    return v;
  endfunction

  function automatic logic [7:0] getch(logic [23:0] v, int ph);
    return ph == 0 ? v[23:16] : ph == 1 ? v[15:8] : v[7:0];
  endfunction

  function automatic void madv();
    if (mph == 2) begin mph = 0; midx = (midx + 1) % 256; end else mph++;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    if (a == 0) begin midx = d[31:24]; mph = 0; end
    else if (a == 4) begin m_pix[midx] = setch(m_pix[midx], mph, d[31:24]); madv(); end
    else if (a == 12) begin m_ovl[midx % 4] = setch(m_ovl[midx % 4], mph, d[31:24]); madv(); end
  endtask

  task automatic rd(input string req);
    logic [31:0] e;
    @(negedge clk); rd_en = 1; #1;
    e = {getch(m_pix[midx], mph), 24'h0};
    chk(rdata === e, req, rdata, e);
    @(negedge clk); rd_en = 0;
    madv();
  endtask

  task automatic look_all(input string req);
    for (int i = 0; i < 256; i++) begin
      pix_idx = 8'(i); #1;
      chk(pix_rgb === m_pix[i], req, {8'h0, pix_rgb}, {8'h0, m_pix[i]});
    end
  endtask

  task automatic ovl_chk(input string req);
    #1;
    chk(ovl2_rgb === m_ovl[2], req, {8'h0, ovl2_rgb}, {8'h0, m_ovl[2]});
    chk(ovl3_rgb === m_ovl[3], req, {8'h0, ovl3_rgb}, {8'h0, m_ovl[3]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_pix[i] = (i == 255) ? 24'hFFFFFF : 24'h0;
    for (int i = 0; i < 4; i++) m_ovl[i] = (i == 0 || i == 2) ? 24'hFFFFFF : 24'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset contents, index 0 and phase red
    look_all("R1");
    ovl_chk("R1");
    rd("R1");
    // R2 R3 R4 R8: stream the whole table from index 0, the index wraps to 0
    wr(4'h0, 32'h0);
    for (int i = 0; i < 256; i++) begin
      wr(4'h4, {8'(i) ^ 8'h5A, 24'h123456});
      wr(4'h4, {8'(i * 3), 24'h0});
      wr(4'h4, {~8'(i), 24'hFFFFFF});
    end
    look_all("R3_R8");
    // R6 R4: read back the whole table from the wrapped index
    for (int i = 0; i < 768; i++) rd("R6_R4");
    // R2: index load in mid-sequence resets phase
    wr(4'h0, 32'h4000_0000);
    wr(4'h4, 32'hAA00_0000);
    wr(4'h0, 32'h4100_0000);
    rd("R2");
    // R7: control write between channel writes is ignored
    wr(4'h0, 32'h0A00_0000);
    wr(4'h4, 32'h1100_0000);
    wr(4'h8, 32'hEE00_0000);
    wr(4'h4, 32'h2200_0000);
    wr(4'h4, 32'h3300_0000);
    wr(4'h2, 32'hDD00_0000);
    look_all("R7");
    rd("R7");
    // R6: shared counter, read continues after a partial write
    wr(4'h0, 32'h1400_0000);
    wr(4'h4, 32'h7700_0000);
    rd("R6");
    rd("R6");
    rd("R6");
    // R5 R9: overlay writes via the low index bits
    wr(4'h0, 32'h0600_0000);
    wr(4'hC, 32'h1000_0000); wr(4'hC, 32'h2000_0000); wr(4'hC, 32'h3000_0000);
    ovl_chk("R5_R9");
    wr(4'hC, 32'h4000_0000); wr(4'hC, 32'h5000_0000); wr(4'hC, 32'h6000_0000);
    ovl_chk("R5_R9");
    look_all("R5");
    rd("R5");
    // R10: write wins over a simultaneous read
    wr(4'h0, 32'h1E00_0000);
    @(negedge clk); addr = 4'h4; wdata = 32'h9900_0000; wr_en = 1; rd_en = 1;
    @(negedge clk); wr_en = 0; rd_en = 0;
    m_pix[midx] = setch(m_pix[midx], mph, 8'h99); madv();
    rd("R10");
    rd("R10");
    rd("R10");
    pix_idx = 8'h1E; #1;
    chk(pix_rgb === m_pix[30], "R10", {8'h0, pix_rgb}, {8'h0, m_pix[30]});
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule